// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is the integer arithmetic stage of a 32-bit core. It has two parts. A combinational datapath computes one of nine add, subtract or multiply operations. A registered status word holds the condition flags. The first operand always comes from a register. For the add and subtract group, the second operand is either a register or an immediate. The multiply-accumulate forms also take a third operand, the addend.

When the set-flags control is high, the block writes the new flags into the status word at the next clock edge. The flags are negative, zero, carry and signed overflow, plus a sticky overflow bit. A separate write port replaces the whole status word, and that is the only way to clear the sticky bit. Status bits outside the flag field, such as the mode and interrupt-mask bits, change only through that write port.

Top module: `int_alu_psw`

## Requirements
- R1: After `rst_ni` is released, `psw_o` equals the reset value 0x00000010.
- R2: Opcode encoding on `op_i`: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 RSB, 5 RSC, 6 MUL, 7 MLA, 8 MLS. For opcodes 0 to 5, operand b is `imm_i` when `use_imm_i` is 1 and `rm_i` otherwise. ADD gives a+b and ADC gives a+b+C, where a is `rn_i` and C is `psw_o[29]`.
- R3: SUB gives a−b, and SBC gives a−b−NOT(C).
- R4: RSB gives b−a, and RSC gives b−a−NOT(C).
- R5: MUL gives the low 32 bits of a*`rm_i`. MLA adds `ra_i` to that product, and MLS subtracts the product from `ra_i`. Only the low 32 bits of the result are kept, and `use_imm_i` has no effect on these opcodes.
- R6: When `set_flags_i` is 1, an add or subtract opcode writes four flags one clock after the edge. N (bit 31) is bit 31 of the result. Z (bit 30) is 1 when the result is zero. C (bit 29) is the carry out of x + y + cin, which for subtracts means "no borrow". V (bit 28) is signed overflow.
- R7: When `set_flags_i` and `psw_we_i` are both 0, `psw_o` holds its value.
- R8: A multiply opcode with `set_flags_i` set updates only N and Z. C, V and Q keep their values.
- R9: Q (bit 27) is set when a flag-setting add or subtract overflows. Once set, Q stays set until the status word is written.
- R10: When `psw_we_i` is 1, `psw_o` takes the value of `psw_wdata_i` at the next edge. This write takes priority over any flag update.
- R11: Opcodes 9 to 15 give a result of 0 and leave `psw_o` unchanged, even when `set_flags_i` is 1.
- R12: Bits 26:0 of `psw_o` change only through the write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| rn_i | input | 32 | First operand |
| rm_i | input | 32 | Second register operand |
| imm_i | input | 32 | Immediate operand |
| use_imm_i | input | 1 | Selects the immediate as operand b |
| ra_i | input | 32 | Addend for MLA and MLS |
| set_flags_i | input | 1 | Update the flags from this operation |
| psw_we_i | input | 1 | Overwrite the whole status word |
| psw_wdata_i | input | 32 | Status word write value |
| result_o | output | 32 | Operation result (combinational) |
| psw_o | output | 32 | Registered status word |

## Verification
`result_o` is combinational, so the bench samples it one nanosecond after driving the inputs, in the same cycle and before the next rising edge. Flag updates and status writes appear on `psw_o` one edge later, so the bench checks them at the following falling edge, before it drives the next operation. Each expected value comes from a 64-bit arithmetic model that carries its own copy of the status word forward. The carry flag read by ADC, SBC and RSC is therefore always the value the previous operation left behind.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3,
    OP_RSB = 4'd4, OP_RSC = 4'd5, OP_MUL = 4'd6, OP_MLA = 4'd7,
    OP_MLS = 4'd8
  } alu_op_e;

  localparam int PSW_W = 32;
  localparam int BIT_N = 31;
  localparam int BIT_Z = 30;
  localparam int BIT_C = 29;
  localparam int BIT_V = 28;
  localparam int BIT_Q = 27;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              c_o,
  output logic              v_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] x, y;
  logic              cin;
  logic [DATA_W:0]   full;

  // All six variants reduce to x + y + cin
  always_comb begin
    x = a_i; y = b_i; cin = 1'b0; valid_o = 1'b1;
    case (op_i)
      OP_ADD: cin = 1'b0;
      OP_ADC: cin = c_i;
      OP_SUB: begin y = ~b_i; cin = 1'b1; end
      OP_SBC: begin y = ~b_i; cin = c_i;  end
      OP_RSB: begin x = b_i; y = ~a_i; cin = 1'b1; end
      OP_RSC: begin x = b_i; y = ~a_i; cin = c_i;  end
      default: begin x = '0; y = '0; valid_o = 1'b0; end
    endcase
  end

  assign full  = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
  assign sum_o = full[DATA_W-1:0];
  assign c_o   = full[DATA_W];
  assign v_o   = (x[DATA_W-1] == y[DATA_W-1]) && (sum_o[DATA_W-1] != x[DATA_W-1]);

  always_comb begin
    if (!valid_o) assert_idle_zero_R11: assert (sum_o == '0);
  end
endmodule

// File: rtl/alu_mul.sv
module alu_mul
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] addend_i,
  output logic [DATA_W-1:0] prod_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] low;

  // Truncated product: low word identical for signed and unsigned inputs
  assign low = a_i * b_i;

  always_comb begin
    valid_o = 1'b1;
    case (op_i)
      OP_MUL:  prod_o = low;
      OP_MLA:  prod_o = low + addend_i;
      OP_MLS:  prod_o = addend_i - low;
      default: begin prod_o = '0; valid_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/psw_reg.sv
module psw_reg
  import alu_pkg::*;
#(
  parameter logic [PSW_W-1:0] RST_VAL = 32'h0000_0010
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PSW_W-1:0] wdata_i,
  input  logic             upd_nz_i,
  input  logic             upd_cv_i,
  input  logic             n_i,
  input  logic             z_i,
  input  logic             c_i,
  input  logic             v_i,
  output logic [PSW_W-1:0] psw_o
);
  logic [PSW_W-1:0] psw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psw_q <= RST_VAL;
    else if (we_i) psw_q <= wdata_i;
    else begin
      if (upd_nz_i) begin
        psw_q[BIT_N] <= n_i;
        psw_q[BIT_Z] <= z_i;
      end
      if (upd_cv_i) begin
        psw_q[BIT_C] <= c_i;
        psw_q[BIT_V] <= v_i;
        if (v_i) psw_q[BIT_Q] <= 1'b1;
      end
    end
  end

  assign psw_o = psw_q;

  assert_hold_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !upd_nz_i && !upd_cv_i) |=> $stable(psw_q));
  assert_write_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (psw_q == $past(wdata_i)));
  assert_q_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psw_q[BIT_Q] && !we_i) |=> psw_q[BIT_Q]);
  assert_low_bits_kept_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(psw_q[BIT_Q-1:0]));
endmodule

// File: rtl/int_alu_psw.sv
module int_alu_psw
  import alu_pkg::*;
#(
  parameter int                DATA_W  = 32,
  parameter logic [PSW_W-1:0]  PSW_RST = 32'h0000_0010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] rn_i,
  input  logic [DATA_W-1:0] rm_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic              use_imm_i,
  input  logic [DATA_W-1:0] ra_i,
  input  logic              set_flags_i,
  input  logic              psw_we_i,
  input  logic [PSW_W-1:0]  psw_wdata_i,
  output logic [DATA_W-1:0] result_o,
  output logic [PSW_W-1:0]  psw_o
);
  logic [DATA_W-1:0] opb, as_sum, mul_res;
  logic as_c, as_v, as_valid, mul_valid, op_valid;

  assign opb = use_imm_i ? imm_i : rm_i;

  alu_addsub #(.DATA_W(DATA_W)) i_addsub (
    .op_i(op_i), .a_i(rn_i), .b_i(opb), .c_i(psw_o[BIT_C]),
    .sum_o(as_sum), .c_o(as_c), .v_o(as_v), .valid_o(as_valid)
  );

  alu_mul #(.DATA_W(DATA_W)) i_mul (
    .op_i(op_i), .a_i(rn_i), .b_i(rm_i), .addend_i(ra_i),
    .prod_o(mul_res), .valid_o(mul_valid)
  );

  assign op_valid = as_valid | mul_valid;
  assign result_o = as_valid ? as_sum : (mul_valid ? mul_res : '0);

  psw_reg #(.RST_VAL(PSW_RST)) i_psw (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(psw_we_i), .wdata_i(psw_wdata_i),
    .upd_nz_i(set_flags_i && op_valid), .upd_cv_i(set_flags_i && as_valid),
    .n_i(result_o[DATA_W-1]), .z_i(result_o == '0), .c_i(as_c), .v_i(as_v),
    .psw_o(psw_o)
  );

  assert_z_tracks_result_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && op_valid && !psw_we_i) |=> (psw_o[BIT_Z] == ($past(result_o) == '0)));
  assert_n_tracks_result_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && op_valid && !psw_we_i) |=> (psw_o[BIT_N] == $past(result_o[DATA_W-1])));
  assert_mul_keeps_cvq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mul_valid && !psw_we_i) |=> $stable(psw_o[BIT_C:BIT_Q]));
  assert_bad_op_no_flags_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid && !psw_we_i) |=> $stable(psw_o));
endmodule

// File: tb/test_int_alu_psw.sv
module test_int_alu_psw;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  op;
  logic [31:0] rn, rm, imm, ra, wdata, result, psw;
  logic        use_imm, set_flags, we;
  logic [31:0] exp_psw;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  int_alu_psw i_int_alu_psw (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .rn_i(rn), .rm_i(rm), .imm_i(imm),
    .use_imm_i(use_imm), .ra_i(ra), .set_flags_i(set_flags), .psw_we_i(we),
    .psw_wdata_i(wdata), .result_o(result), .psw_o(psw)
  );

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string res_tag(input logic [3:0] o);
    if (o <= 4'd1) return "R2";
    if (o <= 4'd3) return "R3";
    if (o <= 4'd5) return "R4";
    if (o <= 4'd8) return "R5";
    return "R11";
  endfunction

  task automatic ref_model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] ad, input logic s, input logic [31:0] p,
                           output logic [31:0] r, output logic [31:0] np);
    longint sa, sb, sr;
    logic [63:0] u;
    logic cf, nb, c, arith, mulop, v;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    cf = p[29]; nb = ~cf; c = 1'b0; sr = 0; arith = 1'b1; mulop = 1'b0; r = '0;
    case (o)
      4'd0, 4'd1: begin
        u  = {32'd0, a} + {32'd0, b} + ((o == 4'd1) ? 64'(cf) : 64'd0);
        r  = u[31:0]; c = u[32];
        sr = sa + sb + ((o == 4'd1) ? longint'(cf) : 0);
      end
      4'd2: begin r = a - b; c = (a >= b); sr = sa - sb; end
      4'd3: begin
        r = a - b - 32'(nb); c = ({32'd0, a} >= {32'd0, b} + 64'(nb));
        sr = sa - sb - longint'(nb);
      end
      4'd4: begin r = b - a; c = (b >= a); sr = sb - sa; end
      4'd5: begin
        r = b - a - 32'(nb); c = ({32'd0, b} >= {32'd0, a} + 64'(nb));
        sr = sb - sa - longint'(nb);
      end
      4'd6, 4'd7, 4'd8: begin
        arith = 1'b0; mulop = 1'b1;
        u = {32'd0, a} * {32'd0, b};
        if (o == 4'd6) r = u[31:0];
        else if (o == 4'd7) r = u[31:0] + ad;
        else r = ad - u[31:0];
      end
      default: begin arith = 1'b0; r = '0; end
    endcase
    v  = arith && (sr > 64'sd2147483647 || sr < -64'sd2147483648);
    np = p;
    if (s && (arith || mulop)) begin
      np[31] = r[31];
      np[30] = (r == 32'd0);
    end
    if (s && arith) begin
      np[29] = c;
      np[28] = v;
      if (v) np[27] = 1'b1;
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the update
  task automatic run_op(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] ad, input logic ui, input logic s,
                        output logic [31:0] got);
    logic [31:0] r, np;
    string ptag;
    op = o; rn = a; ra = ad; set_flags = s; use_imm = ui;
    if (ui && o <= 4'd5) begin imm = b; rm = ~b; end
    else begin rm = b; imm = ~b; end
    ref_model(o, a, b, ad, s, exp_psw, r, np);
    #1;
    got = result;
    check32(res_tag(o), result, r);
    if (o > 4'd8) ptag = "R11 psw";
    else if (!s) ptag = "R7 psw";
    else if (o >= 4'd6) ptag = "R8 psw";
    else ptag = "R6 psw";
    @(posedge clk); @(negedge clk);
    check32(ptag, psw, np);
    exp_psw = np;
    set_flags = 1'b0;
  endtask

  // Write collides with a flag-setting overflowing add; the write must win
  task automatic psw_write(input logic [31:0] val);
    we = 1'b1; wdata = val; set_flags = 1'b1; op = 4'd0;
    rn = 32'h7FFF_FFFF; rm = 32'd1; use_imm = 1'b0;
    @(posedge clk); @(negedge clk);
    we = 1'b0; set_flags = 1'b0;
    check32("R10 write", psw, val);
    exp_psw = val;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] vals [7];
    logic [31:0] got;
    vals = '{32'd0, 32'd1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'hA, 32'h0A0B_0C0D};
    rst_n = 1'b0; op = '0; rn = '0; rm = '0; imm = '0; ra = '0;
    use_imm = 1'b0; set_flags = 1'b0; we = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    check32("R1 reset", psw, 32'h0000_0010);
    rst_n = 1'b1;
    exp_psw = 32'h0000_0010;
    @(negedge clk);
    check32("R1 after release", psw, 32'h0000_0010);

    psw_write(32'h2000_0010);
    run_op(4'd3, 32'hA, 32'h0A0B_0C0D, 32'd0, 1'b0, 1'b0, got);
    check32("R3 sbc example", got, 32'hF5F4_F3FD);
    run_op(4'd4, 32'hA, 32'h0A0B_0C0D, 32'd0, 1'b1, 1'b0, got);
    check32("R4 rsb example", got, 32'h0A0B_0C03);
    run_op(4'd7, 32'hA, 32'hE, 32'd3, 1'b0, 1'b0, got);
    check32("R5 mla example", got, 32'h0000_008F);
    run_op(4'd8, 32'hA, 32'hE, 32'd3, 1'b1, 1'b0, got);
    check32("R5 mls example", got, 32'hFFFF_FF77);

    psw_write(32'h0000_0010);
    run_op(4'd0, 32'h7FFF_FFFF, 32'd1, 32'd0, 1'b0, 1'b1, got);
    check32("R9 q set", {31'd0, psw[27]}, 32'd1);
    run_op(4'd0, 32'd1, 32'd1, 32'd0, 1'b0, 1'b1, got);
    check32("R9 q sticky", {31'd0, psw[27]}, 32'd1);
    psw_write(32'h0000_0010);
    check32("R10 q cleared", {31'd0, psw[27]}, 32'd0);

    psw_write(32'h0000_00F3);
    run_op(4'd2, 32'd0, 32'd1, 32'd0, 1'b0, 1'b1, got);
    run_op(4'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd5, 1'b0, 1'b1, got);
    check32("R12 low bits", {5'd0, psw[26:0]}, 32'h0000_00F3);

    for (int c = 0; c < 2; c++) begin
      for (int s = 0; s < 2; s++) begin
        psw_write((c != 0 ? 32'h2000_0000 : 32'd0) | 32'h0000_00D3);
        for (int o = 0; o < 16; o++)
          for (int i = 0; i < 7; i++)
            for (int j = 0; j < 7; j++)
              for (int ui = 0; ui < 2; ui++)
                run_op(4'(o), vals[i], vals[j], vals[(i + j) % 7], ui[0], s[0], got);
      end
    end

    for (int k = 0; k < 2000; k++)
      run_op(4'($urandom_range(0, 8)), $urandom, $urandom, $urandom,
             1'($urandom), 1'($urandom), got);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule